// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This block holds a processor's four condition flags (negative, zero, carry, overflow) and decides, for each issued instruction, whether that instruction may take effect. Each cycle it receives a 4-bit condition selector, an instruction-valid strobe, a request to update the flags, and a new flag nibble from the ALU. It evaluates the selected condition against the flags it currently holds. The verdict, the retire pulse and the result-write decision are registered on the edge where the valid strobe is high.

A failing predicate still retires the instruction, so the program counter can advance. It blocks both the result write and the flag write. A conditional-select instruction always writes its result: the first operand when the predicate passes and the second when it fails. The flags are also visible, and writable, as a 32-bit status word. An instruction's flag update takes priority over a status-word write made in the same cycle.

Top module: `predicate_unit`

## Requirements
- R1: After reset, the flags are 0000, the status word reads zero, and pass, retire and res_wr_en are low.
- R2: Selector 0000 (equal) passes when Z is set. Selector 0001 (not equal) passes when Z is clear.
- R3: Carry, sign and overflow tests each pass on one flag alone:
  - 0010 passes on C set, and 0011 passes on C clear.
  - 0100 passes on N set, and 0101 passes on N clear.
  - 0110 passes on V set, and 0111 passes on V clear.
- R4: Selector 1000 (unsigned higher) passes only when C is set and Z is clear. Selector 1001 (lower or same) passes when C is clear or Z is set.
- R5: Selector 1010 (signed greater or equal) passes when N equals V. Selector 1011 (signed less) passes when N and V differ.
- R6: Selector 1100 (signed greater) passes when Z is clear and N equals V. Selector 1101 (signed less or equal) passes when Z is set or N differs from V.
- R7: Selectors 1110 and 1111 pass for every flag value.
- R8: The status word carries N, Z, C and V in bits 31, 30, 29 and 28, and its other bits read zero. A status write loads bits 31..28 into the flags, which are visible from the next cycle. The flag nibble ports use bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V.
- R9: Flags change only on an edge where instr_valid, flag_upd and the predicate are all true. An instruction issued in the very next cycle is evaluated against the new flags.
- R10: A non-select instruction whose predicate fails still raises retire, but it keeps res_wr_en low and leaves the flags unchanged. The result of a non-select instruction is op_a.
- R11: A conditional-select instruction (is_csel high) always raises res_wr_en. Its result is op_a when the predicate passes and op_b when it fails.
- R12: retire, pass, res_wr_en and res_data are registered one cycle after the valid edge. retire is low in any cycle that follows an edge with instr_valid low.
- R13: When an instruction's flag update commits in the same cycle as a status write, the instruction's flags win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cond_sel | input | 4 | Condition selector |
| flag_upd | input | 1 | Instruction requests a flag write |
| alu_flags | input | 4 | New flags {N,Z,C,V} from the ALU |
| is_csel | input | 1 | Instruction is a conditional select |
| op_a | input | DATA_W | First operand / plain result |
| op_b | input | DATA_W | Second operand for a select |
| sw_wr_en | input | 1 | Status word write strobe |
| sw_wr_data | input | 32 | Status word write value |
| sw_rd_data | output | 32 | Status word read value |
| flags_q | output | 4 | Current flags {N,Z,C,V} |
| pass | output | 1 | Registered predicate verdict |
| retire | output | 1 | Instruction retires (PC may advance) |
| res_wr_en | output | 1 | Result write enable |
| res_data | output | DATA_W | Result value |

## Verification
The bench builds the block with DATA_W set to 16 rather than the default 32. Sixteen bits are enough for every operand in the bench to be distinct, so a select that picks the wrong operand, or a result taken from the wrong operand, always shows up. The status word's width is fixed, so all sixteen flag values can be loaded through it. Each of the sixteen selectors is then evaluated against every one of those flag values. Back-to-back flag-setting instructions and a flag update that collides with a status write put the forwarding and priority rules within reach.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
  localparam int SW_W     = 32;
  localparam int FLAG_LSB = 28;
  localparam int NFLAGS   = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  // Evaluate one condition code against a flag set.
  function automatic logic cond_holds(cond_e cc, flags_t f);
    logic r;
    case (cc)
      CC_EQ: r = f.z;
      CC_NE: r = !f.z;
      CC_HS: r = f.c;
      CC_LO: r = !f.c;
      CC_MI: r = f.n;
      CC_PL: r = !f.n;
      CC_VS: r = f.v;
      CC_VC: r = !f.v;
      CC_HI: r = f.c && !f.z;
      CC_LS: r = !f.c || f.z;
      CC_GE: r = (f.n == f.v);
      CC_LT: r = (f.n != f.v);
      CC_GT: r = !f.z && (f.n == f.v);
      CC_LE: r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pu_cond_eval.sv
module pu_cond_eval
  import cflag_pkg::*;
(
  input  logic [3:0] cond_sel,
  input  flags_t     flags,
  output logic       pass_c
);
  always_comb pass_c = cond_holds(cond_e'(cond_sel), flags);
endmodule

// File: rtl/pu_flag_reg.sv
module pu_flag_reg
  import cflag_pkg::*;
#(
  parameter int WORD_W = SW_W,
  parameter int LSB    = FLAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  flags_t            upd_val,
  input  logic              sw_wr_en,
  input  logic [WORD_W-1:0] sw_wr_data,
  output flags_t            flags_q,
  output logic [WORD_W-1:0] sw_rd_data
);
  localparam int MSB = LSB + NFLAGS - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (upd_en)   flags_q <= upd_val;
    else if (sw_wr_en) flags_q <= flags_t'(sw_wr_data[MSB:LSB]);
  end

  logic [NFLAGS-1:0] flag_bits;
  assign flag_bits = flags_q;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rd
    if (i >= LSB && i <= MSB) begin : g_flag
      assign sw_rd_data[i] = flag_bits[i-LSB];
    end else begin : g_zero
      assign sw_rd_data[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pu_result_stage.sv
module pu_result_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              pass_c,
  input  logic              is_csel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              retire,
  output logic              pass,
  output logic              res_wr_en,
  output logic [DATA_W-1:0] res_data
);
  logic              wr_c;
  logic [DATA_W-1:0] data_c;

  always_comb begin
    wr_c   = pass_c || is_csel;
    data_c = (is_csel && !pass_c) ? op_b : op_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire    <= 1'b0;
      pass      <= 1'b0;
      res_wr_en <= 1'b0;
      res_data  <= '0;
    end else begin
      retire    <= valid;
      pass      <= valid && pass_c;
      res_wr_en <= valid && wr_c;
      if (valid) res_data <= data_c;
    end
  end
endmodule

// File: rtl/predicate_unit.sv
module predicate_unit
  import cflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [3:0]        cond_sel,
  input  logic              flag_upd,
  input  logic [3:0]        alu_flags,
  input  logic              is_csel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sw_wr_en,
  input  logic [31:0]       sw_wr_data,
  output logic [31:0]       sw_rd_data,
  output logic [3:0]        flags_q,
  output logic              pass,
  output logic              retire,
  output logic              res_wr_en,
  output logic [DATA_W-1:0] res_data
);
  flags_t cur_flags;
  logic   pass_c;
  logic   flag_commit;

  assign flag_commit = instr_valid && flag_upd && pass_c;
  assign flags_q     = cur_flags;

  pu_cond_eval u_eval (
    .cond_sel (cond_sel),
    .flags    (cur_flags),
    .pass_c   (pass_c)
  );

  pu_flag_reg #(.WORD_W(SW_W), .LSB(FLAG_LSB)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (flag_commit),
    .upd_val    (flags_t'(alu_flags)),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .flags_q    (cur_flags),
    .sw_rd_data (sw_rd_data)
  );

  pu_result_stage #(.DATA_W(DATA_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (instr_valid),
    .pass_c    (pass_c),
    .is_csel   (is_csel),
    .op_a      (op_a),
    .op_b      (op_b),
    .retire    (retire),
    .pass      (pass),
    .res_wr_en (res_wr_en),
    .res_data  (res_data)
  );
endmodule

// File: rtl/predicate_unit_checker.sv
module predicate_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_valid,
  input logic [3:0] cond_sel,
  input logic       flag_upd,
  input logic       is_csel,
  input logic       sw_wr_en,
  input logic       pass_c,
  input logic       flag_commit,
  input logic [3:0] flags_q,
  input logic       pass,
  input logic       retire,
  input logic       res_wr_en
);
  a_r12_retire_follows: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> retire);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!retire && !res_wr_en && !pass));
  a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_sel[3:1] == 3'b111) |=> pass);
  a_r10_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !pass_c && !is_csel) |=> (retire && !res_wr_en));
  a_r11_csel_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_csel) |=> res_wr_en);
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_commit && !sw_wr_en) |=> $stable(flags_q));
  a_r10_fail_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !pass_c && !sw_wr_en) |=> $stable(flags_q));
endmodule

bind predicate_unit predicate_unit_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .cond_sel    (cond_sel),
  .flag_upd    (flag_upd),
  .is_csel     (is_csel),
  .sw_wr_en    (sw_wr_en),
  .pass_c      (pass_c),
  .flag_commit (flag_commit),
  .flags_q     (flags_q),
  .pass        (pass),
  .retire      (retire),
  .res_wr_en   (res_wr_en)
);

// File: tb/predicate_unit_bench.sv
`timescale 1ns/1ps
module predicate_unit_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic [3:0]    cond_sel = '0;
  logic          flag_upd = 1'b0;
  logic [3:0]    alu_flags = '0;
  logic          is_csel = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic          sw_wr_en = 1'b0;
  logic [31:0]   sw_wr_data = '0;
  logic [31:0]   sw_rd_data;
  logic [3:0]    flags_q;
  logic          pass;
  logic          retire;
  logic          res_wr_en;
  logic [DW-1:0] res_data;

  always #2.5 clk = ~clk;

  predicate_unit #(.DATA_W(DW)) u_predicate_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_sel(cond_sel),
    .flag_upd(flag_upd), .alu_flags(alu_flags), .is_csel(is_csel),
    .op_a(op_a), .op_b(op_b), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .flags_q(flags_q), .pass(pass), .retire(retire),
    .res_wr_en(res_wr_en), .res_data(res_data)
  );

  typedef struct {
    logic          p;
    logic          wr;
    logic [DW-1:0] data;
    logic [3:0]    fl;
    int            tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  logic [3:0] mflags = '0;
  bit   finished = 0;

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic int code_tag(logic [3:0] cc);
    if (cc[3:1] == 3'd0) return 2;
    if (cc[3] == 1'b0)   return 3;
    case (cc[3:1])
      3'd4: return 4;
      3'd5: return 5;
      3'd6: return 6;
      default: return 7;
    endcase
  endfunction

  // Pairwise view: even code tests a base condition, odd code its inverse.
  function automatic logic model_pass(logic [3:0] cc, logic [3:0] f);
    logic n, z, c, v, base;
    {n, z, c, v} = f;
    case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: return 1'b1;
    endcase
    return cc[0] ? ~base : base;
  endfunction

  task automatic check(bit ok, int tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag_name(tag), what, act, expv);
    end
  endtask

  task automatic issue(logic [3:0] cc, logic upd, logic [3:0] nf,
                       logic [DW-1:0] a, logic [DW-1:0] b, logic cs, int tag,
                       logic sw = 1'b0, logic [31:0] swd = '0);
    exp_t e;
    @(negedge clk);
    instr_valid = 1'b1; cond_sel = cc; flag_upd = upd; alu_flags = nf;
    op_a = a; op_b = b; is_csel = cs; sw_wr_en = sw; sw_wr_data = swd;
    e.p    = model_pass(cc, mflags);
    e.wr   = e.p | cs;
    e.data = (cs && !e.p) ? b : a;
    if (upd && e.p)  e.fl = nf;
    else if (sw)     e.fl = swd[31:28];
    else             e.fl = mflags;
    e.tag  = tag;
    mflags = e.fl;
    exp_q.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    instr_valid = 1'b0; sw_wr_en = 1'b0; flag_upd = 1'b0; is_csel = 1'b0;
  endtask

  task automatic sw_write(logic [31:0] d);
    @(negedge clk);
    instr_valid = 1'b0; sw_wr_en = 1'b1; sw_wr_data = d;
    mflags = d[31:28];
    @(negedge clk);
    sw_wr_en = 1'b0;
    check(sw_rd_data == {mflags, 28'h0}, 8, "status word", sw_rd_data, {mflags, 28'h0});
    check(flags_q == mflags, 8, "flags after status write", flags_q, mflags);
  endtask

  // Monitor: pops one expected item per retired instruction.
  always @(negedge clk) begin
    if (rst_n && retire) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 12, "unexpected retire", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(pass == e.p, e.tag, "pass", pass, e.p);
        check(res_wr_en == e.wr, e.tag, "res_wr_en", res_wr_en, e.wr);
        if (e.wr) check(res_data == e.data, e.tag, "res_data", res_data, e.data);
        check(flags_q == e.fl, e.tag, "flags", flags_q, e.fl);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(flags_q == 4'h0, 1, "reset flags", flags_q, 0);
    check(sw_rd_data == 32'h0, 1, "reset status word", sw_rd_data, 0);
    check(!retire && !pass && !res_wr_en, 1, "reset outputs",
          {retire, pass, res_wr_en}, 0);

    // Sweep every flag value and every selector; odd codes use select form.
    for (int f = 0; f < 16; f++) begin
      sw_write({f[3:0], 28'h5A5_A5A5});
      for (int cc = 0; cc < 16; cc++) begin
        issue(cc[3:0], 1'b0, 4'hF, DW'(f * 64 + cc + 1), DW'(16'hF000 | (f * 16 + cc)),
              cc[0], code_tag(cc[3:0]));
      end
      go_idle();
      go_idle();
    end

    // R9: plain op leaves flags, flag-setting op overwrites, next instr sees them.
    sw_write(32'h0);
    issue(4'hE, 1'b0, 4'hF, 16'h1111, 16'h2222, 1'b0, 9);
    issue(4'hE, 1'b1, 4'b0100, 16'h1234, 16'h0, 1'b0, 9);   // Z set
    issue(4'h0, 1'b1, 4'b1001, 16'h4321, 16'h0, 1'b0, 9);   // EQ passes, N,V set
    issue(4'hA, 1'b0, 4'h0, 16'h5555, 16'h0, 1'b0, 9);      // GE passes on N==V
    issue(4'h1, 1'b0, 4'h0, 16'h6666, 16'h0, 1'b0, 9);      // NE passes (Z clear)
    // R10: failing predicate with flag update request keeps flags, no write.
    issue(4'h0, 1'b1, 4'b0110, 16'h7777, 16'h0, 1'b0, 10);
    issue(4'h2, 1'b1, 4'b0000, 16'h8888, 16'h0, 1'b0, 10);
    // R11: select with failing and passing predicate.
    issue(4'hB, 1'b0, 4'h0, 16'hAAAA, 16'hBBBB, 1'b1, 11);  // LT fails -> b
    issue(4'hA, 1'b0, 4'h0, 16'hCCCC, 16'hDDDD, 1'b1, 11);  // GE passes -> a
    // R13: committed flag update beats a same-cycle status write.
    issue(4'hE, 1'b1, 4'b0011, 16'h0101, 16'h0, 1'b0, 13, 1'b1, 32'hC000_0000);
    // R13 complement: failed update lets the status write land.
    issue(4'h0, 1'b1, 4'b1111, 16'h0202, 16'h0, 1'b0, 13, 1'b1, 32'h8000_0000);
    issue(4'h4, 1'b0, 4'h0, 16'h0303, 16'h0, 1'b0, 13);      // MI passes on N
    go_idle();
    @(negedge clk);
    // R12 idle cycles do not retire.
    check(!retire && !res_wr_en, 12, "idle outputs", {retire, res_wr_en}, 0);
    check(exp_q.size() == 0, 12, "scoreboard drained", exp_q.size(), 0);
    check(sw_rd_data == 32'h8000_0000, 8, "final status word", sw_rd_data, 32'h8000_0000);
    finish_run();
  end
endmodule